// File: doc/BRIEF.md
# Conditional Trap Evaluation Unit

This unit decides whether a compare-and-trap instruction fires. Each cycle it can take two operands, a five-bit condition mask, a word/doubleword select, the address of the instruction and the current machine-state word. It evaluates five relations between the operands at once: signed less and greater, equality, and unsigned less and greater. Each relation is qualified by its own mask bit, and the qualified results are ORed into a single trap decision.

When the trap is taken, the unit also produces the two values an exception handler expects to find saved. The first is a status word: the machine state with the trap-cause flag set and the floating-point, privileged and address-type flags cleared. The second is the address of the trapping instruction. All results come from registers and appear one clock after the input is offered. Instruction decoding, the jump to the handler vector and privilege checking are done elsewhere.

Top module: `trap_eval_unit`

## Requirements
- R1: With mask bit 0 (the LSB of `cond_mask`) set, a trap is taken when A < B as two's-complement values.
- R2: With mask bit 1 set, a trap is taken when A > B as two's-complement values.
- R3: With mask bit 2 set, a trap is taken when A equals B.
- R4: With mask bit 3 set, a trap is taken when A < B as unsigned values.
- R5: With mask bit 4 set, a trap is taken when A > B as unsigned values.
- R6: When `word_sel` is 1, only bits 31:0 of each operand are compared. They are sign-extended for the signed relations and zero-extended for the unsigned relations, so bits 63:32 have no effect.
- R7: On a taken trap, `save_status` equals `cur_state`, except that bit 17 is forced to 1 and bits 20, 18 and 16 are forced to 0 (bit 0 is the LSB).
- R8: On a taken trap, `save_addr` equals the `instr_addr` that was presented with the trapping input.
- R9: Results appear exactly one clock after the input. When `in_valid` is 0, `trap_taken` is 0 on the next cycle, whatever the other inputs are.
- R10: An all-zero `cond_mask` never causes a trap, whatever the operands are.
- R11: When no trap is taken, `save_status` and `save_addr` are both zero.
- R12: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies the inputs this cycle |
| opnd_a | input | 64 | First compare operand |
| opnd_b | input | 64 | Second compare operand |
| cond_mask | input | 5 | Per-relation enable mask (see R1 to R5) |
| word_sel | input | 1 | 1 selects 32-bit comparison |
| instr_addr | input | 64 | Address of the instruction being evaluated |
| cur_state | input | 64 | Current machine-state word |
| trap_taken | output | 1 | Trap decision, one cycle after input |
| save_status | output | 64 | Status word to save on a trap |
| save_addr | output | 64 | Instruction address to save on a trap |

## Verification
All three outputs are registered together. The decision, the status word and the saved address for an input driven in one cycle are therefore all due one clock later, and none of them is due earlier or later than that. The bench drives on the falling edge and pushes the expected triple into a queue. On the next falling edge, after exactly one rising edge, it pops the queue and compares, so each comparison lines up with the single register stage. Cycles with `in_valid` low push an all-zero expectation, and those cycles are checked the same way.

// File: rtl/trap_eval_pkg.sv
package trap_eval_pkg;
    localparam int unsigned XLEN   = 64;
    localparam int unsigned WLEN   = 32;
    localparam int unsigned NREL   = 5;
    // cause-flag positions, LSB = 0
    localparam int unsigned BIT_FP    = 20;
    localparam int unsigned BIT_PRIV  = 18;
    localparam int unsigned BIT_TRAP  = 17;
    localparam int unsigned BIT_ADRT  = 16;

    // relation order matches mask bit order
    typedef enum logic [2:0] {
        REL_LT_S = 3'd0,
        REL_GT_S = 3'd1,
        REL_EQ   = 3'd2,
        REL_LT_U = 3'd3,
        REL_GT_U = 3'd4
    } rel_idx_e;

    typedef struct packed {
        logic            taken;
        logic [XLEN-1:0] status;
        logic [XLEN-1:0] addr;
    } trap_result_t;
endpackage

// File: rtl/trap_opnd_prep.sv
module trap_opnd_prep #(
    parameter int unsigned XW = trap_eval_pkg::XLEN,
    parameter int unsigned WW = trap_eval_pkg::WLEN
) (
    input  logic [XW-1:0] raw,
    input  logic          word_sel,
    output logic [XW-1:0] ext_s,
    output logic [XW-1:0] ext_u
);
    localparam int unsigned UPW = XW - WW;

    always_comb begin
        if (word_sel) begin
            ext_s = {{UPW{raw[WW-1]}}, raw[WW-1:0]};
            ext_u = {{UPW{1'b0}}, raw[WW-1:0]};
        end else begin
            ext_s = raw;
            ext_u = raw;
        end
    end
endmodule

// File: rtl/trap_rel_cmp.sv
module trap_rel_cmp #(
    parameter int unsigned XW = trap_eval_pkg::XLEN,
    parameter int unsigned NR = trap_eval_pkg::NREL
) (
    input  logic [XW-1:0] a_s,
    input  logic [XW-1:0] b_s,
    input  logic [XW-1:0] a_u,
    input  logic [XW-1:0] b_u,
    output logic [NR-1:0] rel
);
    import trap_eval_pkg::*;

    always_comb begin
        rel           = '0;
        rel[REL_LT_S] = $signed(a_s) < $signed(b_s);
        rel[REL_GT_S] = $signed(a_s) > $signed(b_s);
        rel[REL_EQ]   = (a_u == b_u);
        rel[REL_LT_U] = a_u < b_u;
        rel[REL_GT_U] = a_u > b_u;
    end
endmodule

// File: rtl/trap_status_fmt.sv
module trap_status_fmt #(
    parameter int unsigned XW = trap_eval_pkg::XLEN
) (
    input  logic [XW-1:0] state_in,
    output logic [XW-1:0] status_out
);
    import trap_eval_pkg::*;

    localparam logic [XW-1:0] CLR_MASK =
        (XW'(1) << BIT_FP) | (XW'(1) << BIT_PRIV) | (XW'(1) << BIT_ADRT);
    localparam logic [XW-1:0] SET_MASK = XW'(1) << BIT_TRAP;

    always_comb begin
        status_out = (state_in & ~CLR_MASK) | SET_MASK;
    end
endmodule

// File: rtl/trap_eval_unit.sv
module trap_eval_unit
    import trap_eval_pkg::*;
#(
    parameter int unsigned XW = XLEN,
    parameter int unsigned WW = WLEN,
    parameter int unsigned NR = NREL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [XW-1:0] opnd_a,
    input  logic [XW-1:0] opnd_b,
    input  logic [NR-1:0] cond_mask,
    input  logic          word_sel,
    input  logic [XW-1:0] instr_addr,
    input  logic [XW-1:0] cur_state,
    output logic          trap_taken,
    output logic [XW-1:0] save_status,
    output logic [XW-1:0] save_addr
);
    logic [XW-1:0] a_s, a_u, b_s, b_u;
    logic [NR-1:0] rel_hit;
    logic [NR-1:0] qual_hit;
    logic [XW-1:0] fmt_status;
    trap_result_t  res_d, res_q;

    trap_opnd_prep #(.XW(XW), .WW(WW)) u_prep_a (
        .raw(opnd_a), .word_sel(word_sel), .ext_s(a_s), .ext_u(a_u)
    );
    trap_opnd_prep #(.XW(XW), .WW(WW)) u_prep_b (
        .raw(opnd_b), .word_sel(word_sel), .ext_s(b_s), .ext_u(b_u)
    );

    trap_rel_cmp #(.XW(XW), .NR(NR)) u_cmp (
        .a_s(a_s), .b_s(b_s), .a_u(a_u), .b_u(b_u), .rel(rel_hit)
    );

    trap_status_fmt #(.XW(XW)) u_fmt (
        .state_in(cur_state), .status_out(fmt_status)
    );

    for (genvar gi = 0; gi < NR; gi++) begin : g_qual
        assign qual_hit[gi] = rel_hit[gi] & cond_mask[gi];
    end

    always_comb begin
        res_d = '0;
        if (in_valid && (|qual_hit)) begin
            res_d.taken  = 1'b1;
            res_d.status = fmt_status;
            res_d.addr   = instr_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign trap_taken  = res_q.taken;
    assign save_status = res_q.status;
    assign save_addr   = res_q.addr;
endmodule

// File: rtl/trap_eval_chk.sv
module trap_eval_chk #(
    parameter int unsigned XW = 64,
    parameter int unsigned WW = 32,
    parameter int unsigned NR = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [XW-1:0] opnd_a,
    input logic [XW-1:0] opnd_b,
    input logic [NR-1:0] cond_mask,
    input logic          word_sel,
    input logic [XW-1:0] instr_addr,
    input logic [XW-1:0] cur_state,
    input logic          trap_taken,
    input logic [XW-1:0] save_status,
    input logic [XW-1:0] save_addr
);
    logic          pv, pw;
    logic [NR-1:0] pm;
    logic [XW-1:0] pa, pb, ppc, pst;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv <= 1'b0; pw <= 1'b0; pm <= '0;
            pa <= '0; pb <= '0; ppc <= '0; pst <= '0;
        end else begin
            pv <= in_valid; pw <= word_sel; pm <= cond_mask;
            pa <= opnd_a; pb <= opnd_b; ppc <= instr_addr; pst <= cur_state;
        end
    end

    a_r9_idle_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
        !pv |-> !trap_taken);
    a_r10_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (pm == '0) |-> !trap_taken);
    a_r7_cause_flags: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (save_status[17] && !save_status[20] && !save_status[18] && !save_status[16]
                        && save_status[63:21] == pst[63:21] && save_status[19] == pst[19]
                        && save_status[15:0] == pst[15:0]));
    a_r8_addr: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> save_addr == ppc);
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_taken |-> (save_status == '0 && save_addr == '0));
    a_r3_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && pm[2] && (pw ? pa[WW-1:0] == pb[WW-1:0] : pa == pb)) |-> trap_taken);
    a_r4_unsigned_lt: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && pm[3] && !pw && pa < pb) |-> trap_taken);
    a_r5_unsigned_gt: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && pm[4] && !pw && pa > pb) |-> trap_taken);
endmodule

bind trap_eval_unit trap_eval_chk #(.XW(XW), .WW(WW), .NR(NR)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .cond_mask(cond_mask), .word_sel(word_sel),
    .instr_addr(instr_addr), .cur_state(cur_state), .trap_taken(trap_taken),
    .save_status(save_status), .save_addr(save_addr)
);

// File: tb/trap_eval_unit_tb.sv
module trap_eval_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] opnd_a = '0, opnd_b = '0, instr_addr = '0, cur_state = '0;
    logic [4:0]  cond_mask = '0;
    logic        word_sel = 1'b0;
    logic        trap_taken;
    logic [63:0] save_status, save_addr;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic        q_taken[$];
    logic [63:0] q_status[$];
    logic [63:0] q_addr[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_eval_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .cond_mask(cond_mask), .word_sel(word_sel),
        .instr_addr(instr_addr), .cur_state(cur_state), .trap_taken(trap_taken),
        .save_status(save_status), .save_addr(save_addr)
    );

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit ref_trap(input logic [63:0] a, input logic [63:0] b,
                                    input logic [4:0] m, input logic w);
        longint          sa, sb;
        longint unsigned ua, ub;
        bit              t;
        if (w) begin
            sa = longint'(int'(a[31:0]));
            sb = longint'(int'(b[31:0]));
            ua = longint'(a[31:0]);
            ub = longint'(b[31:0]);
        end else begin
            sa = longint'(a); sb = longint'(b);
            ua = a; ub = b;
        end
        t = 0;
        if (m[0] && sa < sb)  t = 1;
        if (m[1] && sa > sb)  t = 1;
        if (m[2] && ua == ub) t = 1;
        if (m[3] && ua < ub)  t = 1;
        if (m[4] && ua > ub)  t = 1;
        return t;
    endfunction

    // Compare due results, then drive the next input. Called at a falling edge.
    task automatic step(input string tag, input bit v, input logic [63:0] a,
                        input logic [63:0] b, input logic [4:0] m, input bit w,
                        input logic [63:0] pc, input logic [63:0] st);
        bit t;
        if (q_taken.size() > 0) begin
            string tg;
            tg = q_tag.pop_front();
            check64({tg, " taken"},  {63'd0, trap_taken}, {63'd0, q_taken.pop_front()});
            check64({tg, " status"}, save_status, q_status.pop_front());
            check64({tg, " addr"},   save_addr,   q_addr.pop_front());
        end
        in_valid = v; opnd_a = a; opnd_b = b; cond_mask = m;
        word_sel = w; instr_addr = pc; cur_state = st;
        t = v && ref_trap(a, b, m, w);
        q_tag.push_back(tag);
        q_taken.push_back(t);
        q_status.push_back(t ? ((st | 64'h2_0000) & ~64'h15_0000) : 64'd0);
        q_addr.push_back(t ? pc : 64'd0);
        @(negedge clk);
    endtask

    initial begin
        logic [63:0] ra, rb;
        repeat (3) @(negedge clk);
        in_valid = 1'b1; cond_mask = 5'h1f; opnd_a = 64'd1; opnd_b = 64'd1;
        instr_addr = 64'h1234; cur_state = '1;
        @(negedge clk);
        check64("R12 reset taken",  {63'd0, trap_taken}, 64'd0);
        check64("R12 reset status", save_status, 64'd0);
        check64("R12 reset addr",   save_addr, 64'd0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        q_taken.delete(); q_status.delete(); q_addr.delete(); q_tag.delete();

        step("R1 slt hit",  1, -64'sd5, 64'd3, 5'b00001, 0, 64'h1000, 64'hFFFF_FFFF_FFFF_FFFF);
        step("R1 slt miss", 1, 64'd7, 64'd3, 5'b00001, 0, 64'h1004, 64'h0);
        step("R2 sgt hit",  1, 64'd9, -64'sd2, 5'b00010, 0, 64'h1008, 64'hA5A5_0000_5A5A_1234);
        step("R2 sgt miss", 1, -64'sd9, 64'd2, 5'b00010, 0, 64'h100C, 64'h0);
        step("R3 eq hit",   1, 64'hDEAD_BEEF, 64'hDEAD_BEEF, 5'b00100, 0, 64'h1010, 64'h0);
        step("R3 eq miss",  1, 64'hDEAD_BEEF, 64'hDEAD_BEE0, 5'b00100, 0, 64'h1014, 64'h0);
        step("R4 ult hit",  1, 64'd3, 64'hFFFF_FFFF_FFFF_FFFF, 5'b01000, 0, 64'h1018, 64'h15_0000);
        step("R4 ult miss", 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 5'b01000, 0, 64'h101C, 64'h0);
        step("R5 ugt hit",  1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 5'b10000, 0, 64'h1020, 64'h7);
        step("R5 ugt miss", 1, 64'd3, 64'hFFFF_FFFF_FFFF_FFFF, 5'b10000, 0, 64'h1024, 64'h0);
        step("R6 word slt", 1, 64'h0000_0001_FFFF_FFFF, 64'd1, 5'b00001, 1, 64'h2000, 64'h0);
        step("R6 dword sgt",1, 64'h0000_0001_FFFF_FFFF, 64'd1, 5'b00001, 0, 64'h2004, 64'h0);
        step("R6 word ugt", 1, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_0000_0000_0001, 5'b10000, 1, 64'h2008, 64'h0);
        step("R6 word eq",  1, 64'hAAAA_0000_1234_5678, 64'h5555_0000_1234_5678, 5'b00100, 1, 64'h200C, 64'h0);
        step("R7 status",   1, 64'd0, 64'd0, 5'b00100, 0, 64'h3000, 64'hFFFF_FFFF_FFFF_FFFF);
        step("R8 addr",     1, 64'd4, 64'd5, 5'b00001, 0, 64'hCAFE_F00D_0000_0040, 64'h0);
        step("R9 invalid",  0, 64'd1, 64'd1, 5'b11111, 0, 64'h4000, 64'hFFFF);
        step("R10 zeromask",1, 64'd1, 64'd1, 5'b00000, 0, 64'h4004, 64'hFFFF);
        step("R11 nohit",   1, 64'd1, 64'd2, 5'b10110, 0, 64'h4008, 64'hFFFF);
        for (int i = 0; i < 400; i++) begin
            ra = {$urandom, $urandom};
            rb = ($urandom_range(0, 3) == 0) ? ra : {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) rb[31:0] = ra[31:0];
            step("RAND", 1'($urandom_range(0, 7) != 0), ra, rb, 5'($urandom),
                 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
        end
        step("R9 drain", 0, 64'd0, 64'd0, 5'd0, 0, 64'd0, 64'd0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule